// File: doc/BRIEF.md
# Microcoded Sticky-Halt Event Controller

This block is a small control unit built as a microprogrammed state machine. On every cycle a fixed control store is read. Its address is made of the current inputs and one state bit that the store fed back to itself on the previous cycle. The word that is read drives three outputs:
- a halt indicator;
- a waiting lamp, lit while nothing is requested;
- a bell, sounded on each event.

The same word also gives the next value of the state bit. A register captures that bit on each clock.

There are three inputs: a halt request and a vector of event lines, two lines by default. A halt request that is seen while the controller runs sets the state bit, and nothing afterwards clears it except reset. From that point the controller reports halted, and the lamp and the bell stay dark whatever the inputs do. The outputs are read from the store combinationally. A halt request therefore shows on the halt indicator in the same cycle it arrives, and the stored bit holds it there on every later cycle.

Top module: `halt_event_ctl`

## Requirements
- R1: After a synchronous active-high reset with all inputs at 0, `halted_o`=0, `wait_lamp`=1 and `bell`=0.
- R2: While the controller is not halted, `halt_req`=1 gives `halted_o`=1, `wait_lamp`=0 and `bell`=0 in that same cycle, whatever the event lines carry.
- R3: After any rising clock edge at which `halt_req` was 1 (outside reset), `halted_o` stays 1 and both `wait_lamp` and `bell` stay 0 on every later cycle until reset, for all input patterns.
- R4: While not halted, with `halt_req`=0 and every event line 0, `wait_lamp`=1, `bell`=0 and `halted_o`=0.
- R5: While not halted, with `halt_req`=0 and at least one event line at 1, `bell`=1, `wait_lamp`=0 and `halted_o`=0.
- R6: Event activity without a halt request never sets the halt state: after such clock edges, `halted_o` stays 0.
- R7: Reset releases a halted controller. After a clock edge with `rst`=1, `halted_o` equals the current `halt_req`.
- R8: While not halted, `wait_lamp` and `bell` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the state bit |
| halt_req | input | 1 | Halt request; latches the halted state |
| events | input | NUM_EVT (2) | Event lines; any bit at 1 is an event |
| halted_o | output | 1 | Halt indicator |
| wait_lamp | output | 1 | Waiting lamp; lit when idle and not halted |
| bell | output | 1 | Bell; sounds on any event while not halted |

## Verification
The store is driven through every combination of halt request and event lines. Each event line is exercised alone and with the other, which separates the lamp term (no request at all) from the bell term (any event). A halt request is applied with the event lines both quiet and active, which shows that halt overrides the bell in the same cycle. After the halt state is latched, all eight input patterns are applied again to show that nothing escapes it. Reset is then applied while the halt request is held high and while it is low, which distinguishes a true release of the state bit from a halt that is simply requested again.

// File: rtl/evctl_pkg.sv
package evctl_pkg;

  // Control word layout, MSB first: next state, halt, lamp, bell
  typedef struct packed {
    logic nxt;
    logic halt;
    logic lamp;
    logic bell;
  } cw_t;

  // Computes one control-store entry from its address fields
  function automatic cw_t cw_gen(input logic st, input logic req, input logic any_ev);
    cw_t w;
    w = '0;
    if (st || req) begin
      w.nxt  = 1'b1;
      w.halt = 1'b1;
    end else begin
      w.lamp = ~any_ev;
      w.bell = any_ev;
    end
    return w;
  endfunction

endpackage

// File: rtl/evctl_store.sv
module evctl_store
  import evctl_pkg::*;
#(
  parameter int NUM_EVT = 2
) (
  input  logic [NUM_EVT+1:0] addr,
  output cw_t                word
);
  localparam int AW    = NUM_EVT + 2;
  localparam int DEPTH = 1 << AW;

  cw_t tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [AW-1:0] IA = AW'(i);
    assign tbl[i] = cw_gen(IA[AW-1], IA[AW-2], |IA[NUM_EVT-1:0]);
  end

  assign word = tbl[addr];
endmodule

// File: rtl/evctl_state.sv
module evctl_state (
  input  logic clk,
  input  logic rst,
  input  logic nxt,
  output logic st
);
  always_ff @(posedge clk) begin
    if (rst) st <= 1'b0;
    else     st <= nxt;
  end
endmodule

// File: rtl/halt_event_ctl.sv
module halt_event_ctl
  import evctl_pkg::*;
#(
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_req,
  input  logic [NUM_EVT-1:0] events,
  output logic               halted_o,
  output logic               wait_lamp,
  output logic               bell
);
  localparam int AW = NUM_EVT + 2;

  logic          st_q;
  logic [AW-1:0] addr;
  cw_t           word;

  assign addr = {st_q, halt_req, events};

  evctl_store #(.NUM_EVT(NUM_EVT)) u_store (
    .addr (addr),
    .word (word)
  );

  evctl_state u_state (
    .clk (clk),
    .rst (rst),
    .nxt (word.nxt),
    .st  (st_q)
  );

  assign halted_o  = word.halt;
  assign wait_lamp = word.lamp;
  assign bell      = word.bell;
endmodule

// File: rtl/evctl_chk.sv
module evctl_chk #(
  parameter int NUM_EVT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               a,
  input logic [NUM_EVT-1:0] ev,
  input logic               x,
  input logic               v,
  input logic               w
);
  p_halt_now_r2: assert property (@(posedge clk) disable iff (rst)
    a |-> (x && !v && !w));

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    x |=> x);

  p_halt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    x |-> (!v && !w));

  p_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (!x && ev == '0) |-> v);

  p_bell_r5: assert property (@(posedge clk) disable iff (rst)
    (!x && ev != '0) |-> (w && !v));

  p_no_self_halt_r6: assert property (@(posedge clk) disable iff (rst)
    (!x && !a) |=> (x == a));

  p_release_r7: assert property (@(posedge clk)
    rst |=> (x == a));

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !x |-> !(v && w));
endmodule

bind halt_event_ctl evctl_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk (clk),
  .rst (rst),
  .a   (halt_req),
  .ev  (events),
  .x   (halted_o),
  .v   (wait_lamp),
  .w   (bell)
);

// File: tb/halt_event_ctl_tb.sv
module halt_event_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_req = 1'b0;
  logic [1:0] events = 2'b00;
  logic       halted_o, wait_lamp, bell;
  int         n_chk = 0;
  int         n_err = 0;

  always #2.5 clk = ~clk;

  halt_event_ctl u_dut (
    .clk       (clk),
    .rst       (rst),
    .halt_req  (halt_req),
    .events    (events),
    .halted_o  (halted_o),
    .wait_lamp (wait_lamp),
    .bell      (bell)
  );

  // Drive at the falling edge, sample 1 ns later (well before the rising edge)
  task automatic drive(input logic r, input logic a, input logic [1:0] e);
    @(negedge clk);
    rst = r; halt_req = a; events = e;
    #1;
  endtask

  task automatic check(input string tag, input logic [2:0] exp);
    logic [2:0] got;
    got = {halted_o, wait_lamp, bell};
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: {x,v,w} got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic t_reset();
    drive(1'b1, 1'b0, 2'b00);
    drive(1'b1, 1'b0, 2'b00);
    drive(1'b0, 1'b0, 2'b00);
    check("R1 reset state idle", 3'b010);
  endtask

  task automatic t_idle_events();
    drive(1'b0, 1'b0, 2'b00); check("R4 idle lamp", 3'b010);
    drive(1'b0, 1'b0, 2'b01); check("R5 event line 0", 3'b001);
    drive(1'b0, 1'b0, 2'b10); check("R5 event line 1", 3'b001);
    drive(1'b0, 1'b0, 2'b11); check("R5 both events", 3'b001);
    drive(1'b0, 1'b0, 2'b00); check("R6 events did not halt", 3'b010);
    check("R8 lamp and bell exclusive", {1'b0, ~bell & wait_lamp, bell & ~wait_lamp});
  endtask

  task automatic t_halt_now();
    drive(1'b0, 1'b1, 2'b11); check("R2 halt overrides bell same cycle", 3'b100);
  endtask

  task automatic t_sticky();
    for (int i = 0; i < 8; i++) begin
      drive(1'b0, i[2], i[1:0]);
      check($sformatf("R3 sticky pattern %0d", i), 3'b100);
    end
  endtask

  task automatic t_release();
    drive(1'b1, 1'b1, 2'b00);
    drive(1'b0, 1'b1, 2'b00); check("R7 reset with request held", 3'b100);
    drive(1'b1, 1'b0, 2'b01);
    drive(1'b0, 1'b0, 2'b01); check("R7 reset released halt", 3'b001);
    drive(1'b0, 1'b1, 2'b00); check("R2 halt request quiet events", 3'b100);
    drive(1'b0, 1'b0, 2'b00); check("R3 latched after edge", 3'b100);
  endtask

  initial begin
    t_reset();
    t_idle_events();
    t_halt_now();
    t_sticky();
    t_release();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule